// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Register Slave

This block lets a host reach a 128-byte space of registers and RAM over an 8-bit bus that carries both address and data. An address strobe marks the address phase. When that strobe falls, the low seven bus lines are captured as the address for the access that follows. The data phase is then run in one of two strobe conventions, and a mode input picks which one.

- **Level-qualified convention:** a positive data strobe is combined with a read/write level.
- **Separate-strobe convention:** an active-low read strobe and an active-low write strobe are used. This convention applies whenever the mode input is low.

The slave drives read data onto the bus only while a read window is open, and releases the bus otherwise. Each write becomes a single-cycle request, with a byte mask, to the storage array behind the slave. Access is blocked when chip select is missing, when supply power is not good, or while the bus reset input is held low. Three fixed locations are protected from writes: two whole bytes, and the top bit of a third. All bus pins are synchronised into a fast system clock before any edge is detected. The storage array sits outside the block and returns read data combinationally for the latched address.

Top module: `mux_bus_slave`

## Requirements
- R1: On a synchronised falling edge of `asIn`, `memAddr` takes bits 6..0 of the bus. Bit 7 is ignored. `memAddr` changes at no other time.
- R2: With `motSel` high, a write is issued when `dsIn` falls while `rwIn` was low during the strobe. The write carries the bus byte and uses the latched address. `memWrEn` is high for exactly one cycle.
- R3: With `motSel` high, the bus is driven (`adOe`=1) while `dsIn` is high and `rwIn` is high. During that time `adOut` equals the stored byte at `memAddr`. The bus floats once `dsIn` falls.
- R4: With `motSel` low, `dsIn` acts as an active-low read strobe. The bus is driven while it is low and floats when it rises.
- R5: With `motSel` low, `rwIn` acts as an active-low write strobe. Its rising edge issues the write with the bus byte.
- R6: With `csN` high, no write is issued and the bus is never driven. The address is still latched.
- R7: While `pwrGood` is low, all bus inputs are ignored: there is no address latch, no write, and no drive.
- R8: While `busRstN` is low, all bus inputs are ignored in the same way as R7.
- R9: Writes to address 0x0C and address 0x0D are dropped. A write to address 0x0A has `memWrMask` = 0x7F, so bit 7 is preserved. Every other write has mask 0xFF.
- R10: Every bus pin passes through two synchroniser stages. The resulting output change appears on the third rising clock edge after the pin changes.
- R11: If the address-strobe fall and the write-ending edge are detected in the same cycle, the write goes to the previously latched address. The new address takes effect afterwards.
- R12: After `rstN` is released, the block starts with `memAddr`=0, `adOe`=0 and `memWrEn`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset of all flops |
| motSel | input | 1 | 1 = data strobe plus read/write level; 0 = separate active-low read/write strobes |
| asIn | input | 1 | Address strobe; address captured on its falling edge |
| dsIn | input | 1 | Data strobe (mode 1) or active-low read (mode 0) |
| rwIn | input | 1 | Read/write level (mode 1) or active-low write (mode 0) |
| csN | input | 1 | Active-low chip select |
| pwrGood | input | 1 | Supply-valid indication; low blocks all access |
| busRstN | input | 1 | Active-low bus reset; low blocks all access |
| adIn | input | 8 | Bus lines as seen by the slave |
| adOut | output | 8 | Read data to the bus |
| adOe | output | 1 | Bus drive enable |
| memAddr | output | 7 | Latched address, used as the read address of the storage |
| memRdData | input | 8 | Storage byte at `memAddr` |
| memWrEn | output | 1 | Single-cycle write request |
| memWrAddr | output | 7 | Write address |
| memWrData | output | 8 | Write data |
| memWrMask | output | 8 | Per-bit write mask |

## Verification
The two functions that can land in the same cycle are the address capture and the completion of a write. A late address-strobe fall can coincide with the rising edge of the write strobe. The bench provokes this by raising the write strobe and dropping the address strobe on the same clock, with the bus holding one byte that serves as both the data and the new address. It then judges the outcome from the storage contents and from `memAddr`. The byte must appear at the old address. The new address must be visible afterwards. The byte must not appear at the new address.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  // Synchronised view of the bus control pins
  typedef struct packed {
    logic mot;
    logic rstOk;
    logic pwr;
    logic csN;
    logic rw;
    logic ds;
    logic as;
  } ctrlPins_t;

  // Idle value of the synchronisers after reset: no access possible
  localparam ctrlPins_t PINS_IDLE = '{mot: 1'b0, rstOk: 1'b0, pwr: 1'b0,
                                      csN: 1'b1, rw: 1'b1, ds: 1'b1, as: 1'b0};

  // Strobes passed from control to datapath
  typedef struct packed {
    logic latchAddr;
    logic wrFire;
    logic rdActive;
  } busStrobe_t;

endpackage

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       motSel,
  input  logic       asIn,
  input  logic       dsIn,
  input  logic       rwIn,
  input  logic       csN,
  input  logic       pwrGood,
  input  logic       busRstN,
  output busStrobe_t strb
);

  localparam int LAST = SYNC_STAGES - 1;

  ctrlPins_t pinNow;
  ctrlPins_t syncChain [SYNC_STAGES];
  ctrlPins_t cur;
  ctrlPins_t prv;

  assign pinNow = '{mot: motSel, rstOk: busRstN, pwr: pwrGood,
                    csN: csN, rw: rwIn, ds: dsIn, as: asIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncChain[i] <= PINS_IDLE;
      prv <= PINS_IDLE;
    end else begin
      syncChain[0] <= pinNow;
      for (int i = 1; i < SYNC_STAGES; i++) syncChain[i] <= syncChain[i-1];
      prv <= syncChain[LAST];
    end
  end

  assign cur = syncChain[LAST];

  logic accessOk;
  logic asFall;
  logic levelWrEnd;
  logic strobeWrEnd;
  logic wrEdge;
  logic rdWindow;

  always_comb begin
    accessOk    = cur.pwr & cur.rstOk;
    asFall      = prv.as & ~cur.as;
    levelWrEnd  = prv.ds & ~cur.ds & ~prv.rw;
    strobeWrEnd = ~prv.rw & cur.rw;
    wrEdge      = cur.mot ? levelWrEnd : strobeWrEnd;
    rdWindow    = cur.mot ? (cur.ds & cur.rw) : ~cur.ds;
    strb.latchAddr = asFall & accessOk;
    strb.wrFire    = wrEdge & ~prv.csN & accessOk;
    strb.rdActive  = rdWindow & ~cur.csN & accessOk;
  end

  // R1: an address-strobe fall cannot be seen in two consecutive cycles
  p_latch_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchAddr |=> !strb.latchAddr);

endmodule

// File: rtl/mbs_dp.sv
module mbs_dp
  import mbs_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RO_ADDR_LO  = 12,
  parameter int RO_ADDR_HI  = 13,
  parameter int PART_ADDR   = 10,
  parameter int PART_MASK   = 8'h7F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] adIn,
  input  busStrobe_t        strb,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] memWrMask
);

  localparam int LAST = SYNC_STAGES - 1;
  localparam logic [ADDR_W-1:0] RO_LO = ADDR_W'(RO_ADDR_LO);
  localparam logic [ADDR_W-1:0] RO_HI = ADDR_W'(RO_ADDR_HI);
  localparam logic [ADDR_W-1:0] PART  = ADDR_W'(PART_ADDR);
  localparam logic [DATA_W-1:0] PMASK = DATA_W'(PART_MASK);

  logic [DATA_W-1:0] adChain [SYNC_STAGES];
  logic [DATA_W-1:0] adCur;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) adChain[i] <= '0;
    end else begin
      adChain[0] <= adIn;
      for (int i = 1; i < SYNC_STAGES; i++) adChain[i] <= adChain[i-1];
    end
  end

  assign adCur = adChain[LAST];

  logic roHit;
  logic [DATA_W-1:0] maskNext;

  always_comb begin
    roHit    = (memAddr == RO_LO) || (memAddr == RO_HI);
    maskNext = (memAddr == PART) ? PMASK : '1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr   <= '0;
      memWrEn   <= 1'b0;
      memWrAddr <= '0;
      memWrData <= '0;
      memWrMask <= '0;
      adOe      <= 1'b0;
      adOut     <= '0;
    end else begin
      if (strb.latchAddr) memAddr <= adCur[ADDR_W-1:0];
      memWrEn <= strb.wrFire & ~roHit;
      if (strb.wrFire) begin
        memWrAddr <= memAddr;
        memWrData <= adCur;
        memWrMask <= maskNext;
      end
      adOe  <= strb.rdActive;
      adOut <= strb.rdActive ? memRdData : '0;
    end
  end

  // R2: a write request lasts one cycle
  p_wr_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> !memWrEn);
  // R9: protected locations never receive a write
  p_ro_block_r9: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrAddr != RO_LO && memWrAddr != RO_HI));
  // R3: bus is driven only after the control opened a read window
  p_drive_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    adOe |-> $past(strb.rdActive));
  // R1: the address holds unless a capture was signalled
  p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchAddr |=> $stable(memAddr));

endmodule

// File: rtl/mux_bus_slave.sv
module mux_bus_slave
  import mbs_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              motSel,
  input  logic              asIn,
  input  logic              dsIn,
  input  logic              rwIn,
  input  logic              csN,
  input  logic              pwrGood,
  input  logic              busRstN,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [DATA_W-1:0] memWrMask
);

  busStrobe_t strb;

  mbs_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .motSel(motSel), .asIn(asIn), .dsIn(dsIn),
    .rwIn(rwIn), .csN(csN), .pwrGood(pwrGood), .busRstN(busRstN),
    .strb(strb)
  );

  mbs_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .adIn(adIn), .strb(strb), .memRdData(memRdData),
    .adOut(adOut), .adOe(adOe), .memAddr(memAddr), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrMask(memWrMask)
  );

endmodule

// File: tb/mux_bus_slave_tb.sv
module mux_bus_slave_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic motSel = 1'b0, asIn = 1'b0, dsIn = 1'b1, rwIn = 1'b1, csN = 1'b1;
  logic pwrGood = 1'b1, busRstN = 1'b1;
  logic [7:0] adIn = 8'h00;
  logic [7:0] adOut, memRdData, memWrData, memWrMask;
  logic [6:0] memAddr, memWrAddr;
  logic adOe, memWrEn;

  logic [7:0] mem [128];
  int totalCnt = 0;
  int failCnt = 0;
  string curReq = "R12";

  always #4 clk = ~clk;

  assign memRdData = mem[memAddr];

  mux_bus_slave u_dut (
    .clk(clk), .rstN(rstN), .motSel(motSel), .asIn(asIn), .dsIn(dsIn),
    .rwIn(rwIn), .csN(csN), .pwrGood(pwrGood), .busRstN(busRstN),
    .adIn(adIn), .adOut(adOut), .adOe(adOe), .memAddr(memAddr),
    .memRdData(memRdData), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memWrMask(memWrMask)
  );

  task automatic check(string req, string what, int act, int exp);
    totalCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    bit as, ds, rw, cs, pwr, rst, mot;
    bit [7:0] ad;
  } snap_t;

  snap_t hist[$];
  bit [6:0] eAddr, eWrAddr;
  bit [7:0] eWrData, eWrMask, eOut;
  bit eWrEn, eOe;

  function automatic snap_t idleSnap();
    snap_t s;
    s.as = 0; s.ds = 1; s.rw = 1; s.cs = 1; s.pwr = 0; s.rst = 0; s.mot = 0; s.ad = 0;
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      hist = {};
      repeat (3) hist.push_back(idleSnap());
      eAddr = 0; eWrAddr = 0; eWrData = 0; eWrMask = 0; eOut = 0;
      eWrEn = 0; eOe = 0;
    end else begin
      snap_t s, c, p;
      bit ok, wrEnd, rd;
      s.as = asIn; s.ds = dsIn; s.rw = rwIn; s.cs = csN; s.pwr = pwrGood;
      s.rst = busRstN; s.mot = motSel; s.ad = adIn;
      hist.push_back(s);
      if (hist.size() > 4) void'(hist.pop_front());
      c = hist[1];
      p = hist[0];
      ok = c.pwr && c.rst;
      if (c.mot) begin
        wrEnd = p.ds && !c.ds && !p.rw;
        rd = c.ds && c.rw;
      end else begin
        wrEnd = !p.rw && c.rw;
        rd = !c.ds;
      end
      wrEnd = wrEnd && !p.cs && ok;
      rd = rd && !c.cs && ok;
      eOe = rd;
      eOut = rd ? mem[eAddr] : 8'h00;
      eWrEn = wrEnd && eAddr != 7'h0C && eAddr != 7'h0D;
      if (wrEnd) begin
        eWrAddr = eAddr;
        eWrData = c.ad;
        eWrMask = (eAddr == 7'h0A) ? 8'h7F : 8'hFF;
      end
      if (p.as && !c.as && ok) eAddr = c.ad[6:0];
    end
  end

  // compare every cycle, then let the storage take the write
  always @(negedge clk) begin
    check(curReq, "memAddr", memAddr, eAddr);
    check(curReq, "adOe", adOe, eOe);
    check(curReq, "adOut", adOut, eOut);
    check(curReq, "memWrEn", memWrEn, eWrEn);
    if (eWrEn) begin
      check(curReq, "memWrAddr", memWrAddr, eWrAddr);
      check(curReq, "memWrData", memWrData, eWrData);
      check(curReq, "memWrMask", memWrMask, eWrMask);
    end
    if (memWrEn)
      mem[memWrAddr] = (mem[memWrAddr] & ~memWrMask) | (memWrData & memWrMask);
  end

  // ---------------- bus tasks ----------------
  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latchAddr(bit [7:0] a);
    asIn = 1; adIn = a; waitN(3);
    asIn = 0; waitN(3);
  endtask

  task automatic setMode(bit m);
    csN = 1;
    motSel = m;
    dsIn = m ? 1'b0 : 1'b1;
    rwIn = 1;
    waitN(4);
  endtask

  task automatic strobeWrite(bit [7:0] d, bit cs);
    csN = cs; adIn = d;
    if (motSel) begin
      rwIn = 0; dsIn = 1; waitN(4);
      dsIn = 0; waitN(4);
      rwIn = 1;
    end else begin
      rwIn = 0; waitN(4);
      rwIn = 1; waitN(4);
    end
    csN = 1; waitN(2);
  endtask

  task automatic strobeRead(string req, bit cs, bit expDrive, bit [7:0] expVal);
    csN = cs;
    if (motSel) begin rwIn = 1; dsIn = 1; end
    else dsIn = 0;
    waitN(5);
    check(req, "drive in window", adOe, expDrive);
    if (expDrive) check(req, "read byte", adOut, expVal);
    dsIn = motSel ? 1'b0 : 1'b1;
    waitN(4);
    check(req, "float after window", adOe, 0);
    csN = 1; waitN(2);
  endtask

  // ---------------- scenarios ----------------
  task automatic runTests();
    bit [7:0] old;
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 7 + 3);
    waitN(3);
    check("R12", "reset memAddr", memAddr, 0);
    check("R12", "reset adOe", adOe, 0);
    check("R12", "reset memWrEn", memWrEn, 0);
    rstN = 1;
    waitN(4);

    // R10: read strobe reaches adOe on the third edge
    curReq = "R10";
    latchAddr(8'h05);
    csN = 0; dsIn = 0;
    @(negedge clk); @(negedge clk);
    check("R10", "adOe after two edges", adOe, 0);
    @(negedge clk);
    check("R10", "adOe after three edges", adOe, 1);
    check("R10", "byte after three edges", adOut, mem[5]);
    dsIn = 1; waitN(4); csN = 1; waitN(2);

    // R1: bit 7 of the bus ignored for the address
    curReq = "R1";
    latchAddr(8'hB1);
    check("R1", "address bit7 dropped", memAddr, 8'h31);

    // R5 / R4: separate-strobe write then read
    curReq = "R5";
    latchAddr(8'h21);
    strobeWrite(8'h5A, 0);
    check("R5", "stored byte", mem[8'h21], 8'h5A);
    curReq = "R4";
    strobeRead("R4", 0, 1, 8'h5A);

    // R2 / R3: level-qualified write then read
    setMode(1);
    curReq = "R2";
    latchAddr(8'h40);
    strobeWrite(8'hC3, 0);
    check("R2", "stored byte", mem[8'h40], 8'hC3);
    curReq = "R3";
    strobeRead("R3", 0, 1, 8'hC3);

    // R9: protected locations
    curReq = "R9";
    latchAddr(8'h0C); old = mem[12];
    strobeWrite(8'hFF, 0);
    check("R9", "0x0C unchanged", mem[12], old);
    latchAddr(8'h0D); old = mem[13];
    strobeWrite(8'h00, 0);
    check("R9", "0x0D unchanged", mem[13], old);
    latchAddr(8'h0A); old = mem[10];
    strobeWrite(8'hFF, 0);
    check("R9", "0x0A bit7 kept", mem[10], {old[7], 7'h7F});
    latchAddr(8'h0B);
    strobeWrite(8'h80, 0);
    check("R9", "0x0B full write", mem[11], 8'h80);

    // R6: no chip select
    setMode(0);
    curReq = "R6";
    latchAddr(8'h22); old = mem[8'h22];
    check("R6", "address latched without cs", memAddr, 8'h22);
    strobeWrite(8'h11, 1);
    check("R6", "no write without cs", mem[8'h22], old);
    strobeRead("R6", 1, 0, 8'h00);

    // R7: power not good
    curReq = "R7";
    pwrGood = 0; waitN(3);
    latchAddr(8'h23);
    check("R7", "no address latch", memAddr, 8'h22);
    old = mem[8'h22];
    strobeWrite(8'h77, 0);
    check("R7", "no write", mem[8'h22], old);
    strobeRead("R7", 0, 0, 8'h00);
    pwrGood = 1; waitN(3);

    // R8: bus reset held
    setMode(1);
    curReq = "R8";
    busRstN = 0; waitN(3);
    latchAddr(8'h24);
    check("R8", "no address latch", memAddr, 8'h22);
    old = mem[8'h22];
    strobeWrite(8'h66, 0);
    check("R8", "no write", mem[8'h22], old);
    strobeRead("R8", 0, 0, 8'h00);
    busRstN = 1; waitN(3);

    // R11: address capture and write end in the same cycle
    setMode(0);
    curReq = "R11";
    latchAddr(8'h20);
    old = mem[8'h35];
    csN = 0; rwIn = 0; asIn = 1; adIn = 8'h35; waitN(4);
    asIn = 0; rwIn = 1; waitN(4);
    csN = 1; waitN(2);
    check("R11", "write at old address", mem[8'h20], 8'h35);
    check("R11", "new address untouched", mem[8'h35], old);
    check("R11", "new address latched", memAddr, 8'h35);
    waitN(4);
  endtask

  initial begin
    fork
      runTests();
      begin
        repeat (150000) @(posedge clk);
        failCnt++; totalCnt++;
        $display("FAIL watchdog actual=timeout expected=finished");
      end
    join_any
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule